// File: doc/BRIEF.md
# Outstanding Transfer Request Tracker

This block sits between the read engine and the write engine of a DMA transfer controller. It lets the read side begin fetching data for a new transfer request (TR) while the writes of earlier TRs are still draining. Read work for later TRs can therefore overlap write work for earlier ones, which hides read latency when many small TRs arrive back to back.

The tracker counts the TRs whose reads have started but whose writes have not yet finished. That count may not exceed the number of entries in the destination FIFO. When the count reaches that limit, the tracker withdraws its accept signal, and the read side must hold off on the next TR. Each TR reads from a single source endpoint. The tracker keeps those endpoint IDs in start order and shows the endpoint of the oldest unfinished TR. A completion pulse that arrives when no TR is outstanding is reported as a protocol error.

Top module: `otr_tracker`

## Requirements
- R1: After a synchronous reset, `out_count` is 0, `rd_accept` is 1 and `proto_err` is 0.
- R2: A `rd_start` pulse while `rd_accept` is 1 raises `out_count` by one at the next clock edge, unless a valid completion happens in the same cycle.
- R3: A `wr_done` pulse while `out_count` is nonzero lowers `out_count` by one at the next clock edge, unless an accepted start happens in the same cycle.
- R4: An accepted start and a valid completion in the same cycle leave `out_count` unchanged.
- R5: `out_count` never exceeds ENTRIES (default 4). `rd_accept` is 0 exactly when `out_count` equals ENTRIES.
- R6: A `rd_start` pulse while `rd_accept` is 0 is ignored. The count does not change, and its `rd_ep` value is not recorded, so the next accepted start's endpoint is the one that appears at the head once the older TRs drain.
- R7: A `wr_done` pulse while `out_count` is 0 makes `proto_err` equal 1 for exactly the next cycle, and leaves the count at 0. A start in that same cycle still counts.
- R8: When `out_count` is nonzero, `head_ep` equals the `rd_ep` of the oldest accepted TR that has not completed. Endpoints leave the head in the order their TRs were accepted.
- R9: When the tracker is full, a `wr_done` pulse makes `rd_accept` equal 1 again at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_start | input | 1 | One-cycle pulse: the read side begins a TR |
| rd_ep | input | EP_W | Source endpoint ID of the TR that is starting |
| wr_done | input | 1 | One-cycle pulse: the writes of the oldest TR are finished |
| rd_accept | output | 1 | Registered; 1 when another TR may start |
| out_count | output | $clog2(ENTRIES+1) | Registered count of outstanding TRs |
| head_ep | output | EP_W | Endpoint ID of the oldest outstanding TR |
| proto_err | output | 1 | Registered one-cycle flag for a completion with nothing outstanding |

## Verification
The count is driven with four kinds of pattern:
- starts only, up to the limit, which shows the increment and the point where accept drops;
- completions only, down to zero, which shows the decrement and accept reopening one cycle after the first completion;
- start and completion in the same cycle at a middle count, at the full count and at zero, which separates the net-zero case from an ignored start and from an invalid completion;
- starts refused while full, followed by a drain and a fresh start.

The last pattern shows whether a refused endpoint ID leaked into the order queue. Distinct endpoint IDs on every start let the head sequence reveal any reordering or pointer slip.

// File: rtl/otr_pkg.sv
package otr_pkg;
  // Per-cycle actions decoded from the handshake pulses
  typedef struct packed {
    logic push;     // start accepted: count up, record endpoint
    logic pop;      // valid completion: count down, retire head
    logic bad_pop;  // completion while nothing is outstanding
  } otr_ctl_t;
endpackage

// File: rtl/otr_ctl.sv
module otr_ctl
  import otr_pkg::*;
(
  input  logic     rd_start,
  input  logic     wr_done,
  input  logic     accept,
  input  logic     empty,
  output otr_ctl_t ctl
);
  always_comb begin
    ctl.push    = rd_start & accept;
    ctl.pop     = wr_done & ~empty;
    ctl.bad_pop = wr_done & empty;
  end
endmodule

// File: rtl/otr_count.sv
module otr_count #(
  parameter int ENTRIES = 4,
  parameter int CNT_W   = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  output logic [CNT_W-1:0] count,
  output logic             accept,
  output logic             empty
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(ENTRIES);

  logic [CNT_W-1:0] nxt;

  always_comb begin
    nxt = count;
    unique case ({push, pop})
      2'b10:   nxt = count + 1'b1;
      2'b01:   nxt = count - 1'b1;
      default: nxt = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      accept <= 1'b1;
    end else begin
      count  <= nxt;
      accept <= (nxt != FULL);
    end
  end

  assign empty = (count == '0);
endmodule

// File: rtl/otr_tagq.sv
module otr_tagq #(
  parameter int ENTRIES = 4,
  parameter int EP_W    = 4,
  parameter int PTR_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic            pop,
  input  logic [EP_W-1:0] din,
  output logic [EP_W-1:0] head
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [EP_W-1:0]  mem [ENTRIES];
  logic [PTR_W-1:0] wp, rp;

  // Storage has no reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
    end
  end

  assign head = mem[rp];
endmodule

// File: rtl/otr_tracker.sv
module otr_tracker #(
  parameter int ENTRIES = 4,
  parameter int EP_W    = 4,
  parameter int CNT_W   = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_start,
  input  logic [EP_W-1:0]  rd_ep,
  input  logic             wr_done,
  output logic             rd_accept,
  output logic [CNT_W-1:0] out_count,
  output logic [EP_W-1:0]  head_ep,
  output logic             proto_err
);
  import otr_pkg::*;

  otr_ctl_t ctl;
  logic     empty;

  otr_ctl u_ctl (
    .rd_start (rd_start),
    .wr_done  (wr_done),
    .accept   (rd_accept),
    .empty    (empty),
    .ctl      (ctl)
  );

  otr_count #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst    (rst),
    .push   (ctl.push),
    .pop    (ctl.pop),
    .count  (out_count),
    .accept (rd_accept),
    .empty  (empty)
  );

  otr_tagq #(.ENTRIES(ENTRIES), .EP_W(EP_W)) u_tagq (
    .clk  (clk),
    .rst  (rst),
    .push (ctl.push),
    .pop  (ctl.pop),
    .din  (rd_ep),
    .head (head_ep)
  );

  always_ff @(posedge clk) begin
    if (rst) proto_err <= 1'b0;
    else     proto_err <= ctl.bad_pop;
  end
endmodule

// File: rtl/otr_tracker_chk.sv
module otr_tracker_chk #(
  parameter int ENTRIES = 4,
  parameter int CNT_W   = $clog2(ENTRIES + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_start,
  input logic             wr_done,
  input logic             rd_accept,
  input logic [CNT_W-1:0] out_count,
  input logic             proto_err
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(ENTRIES);

  p_inc_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_start && rd_accept && !wr_done) |=> (out_count == $past(out_count) + 1'b1));

  p_dec_r3: assert property (@(posedge clk) disable iff (rst)
    (!rd_start && wr_done && out_count != '0) |=> (out_count == $past(out_count) - 1'b1));

  p_net_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_start && rd_accept && wr_done && out_count != '0) |=> $stable(out_count));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    out_count <= FULL);

  p_accept_full_r5: assert property (@(posedge clk) disable iff (rst)
    rd_accept == (out_count != FULL));

  p_refused_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_start && !rd_accept && !wr_done) |=> $stable(out_count));

  p_err_set_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_done && out_count == '0) |=> proto_err);

  p_err_clr_r7: assert property (@(posedge clk) disable iff (rst)
    !(wr_done && out_count == '0) |=> !proto_err);

  p_reopen_r9: assert property (@(posedge clk) disable iff (rst)
    (!rd_accept && wr_done) |=> rd_accept);
endmodule

bind otr_tracker otr_tracker_chk #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .rd_start  (rd_start),
  .wr_done   (wr_done),
  .rd_accept (rd_accept),
  .out_count (out_count),
  .proto_err (proto_err)
);

// File: tb/otr_tracker_tb_top.sv
`timescale 1ns/1ps
module otr_tracker_tb_top;
  localparam int ENTRIES = 4;
  localparam int EP_W    = 4;
  localparam int CNT_W   = $clog2(ENTRIES + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             rd_start = 1'b0;
  logic [EP_W-1:0]  rd_ep = '0;
  logic             wr_done = 1'b0;
  logic             rd_accept;
  logic [CNT_W-1:0] out_count;
  logic [EP_W-1:0]  head_ep;
  logic             proto_err;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  otr_tracker #(.ENTRIES(ENTRIES), .EP_W(EP_W)) dut_i (
    .clk(clk), .rst(rst), .rd_start(rd_start), .rd_ep(rd_ep), .wr_done(wr_done),
    .rd_accept(rd_accept), .out_count(out_count), .head_ep(head_ep), .proto_err(proto_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one cycle of stimulus, then settle just after the edge
  task automatic cyc(input bit s, input bit d, input int ep);
    @(negedge clk);
    rd_start = s;
    wr_done  = d;
    rd_ep    = EP_W'(ep);
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 0);
  endtask

  task automatic t_reset();
    chk("R1 count", int'(out_count), 0);
    chk("R1 accept", int'(rd_accept), 1);
    chk("R1 err", int'(proto_err), 0);
  endtask

  task automatic t_fill();
    cyc(1, 0, 3);  chk("R2 count1", int'(out_count), 1);
    chk("R8 head first", int'(head_ep), 3);
    cyc(1, 0, 5);  chk("R2 count2", int'(out_count), 2);
    cyc(1, 0, 9);  chk("R2 count3", int'(out_count), 3);
    chk("R5 accept below full", int'(rd_accept), 1);
    cyc(1, 0, 12); chk("R2 count4", int'(out_count), 4);
    chk("R5 accept full", int'(rd_accept), 0);
    chk("R8 head still oldest", int'(head_ep), 3);
  endtask

  task automatic t_refuse_drain();
    cyc(1, 0, 7);  chk("R6 refused count", int'(out_count), 4);
    chk("R6 accept stays low", int'(rd_accept), 0);
    cyc(0, 1, 0);  chk("R3 count3", int'(out_count), 3);
    chk("R9 reopen", int'(rd_accept), 1);
    chk("R8 head 2nd", int'(head_ep), 5);
    cyc(0, 1, 0);  chk("R8 head 3rd", int'(head_ep), 9);
    cyc(0, 1, 0);  chk("R8 head 4th", int'(head_ep), 12);
    chk("R3 count1", int'(out_count), 1);
    cyc(0, 1, 0);  chk("R3 count0", int'(out_count), 0);
    chk("R7 no err on valid pop", int'(proto_err), 0);
    cyc(1, 0, 2);  chk("R6 refused ep not queued", int'(head_ep), 2);
  endtask

  task automatic t_both();
    cyc(1, 1, 6);  chk("R4 net zero", int'(out_count), 1);
    chk("R8 head after swap", int'(head_ep), 6);
    cyc(0, 1, 0);  chk("R3 back to 0", int'(out_count), 0);
  endtask

  task automatic t_err();
    cyc(0, 1, 0);  chk("R7 err set", int'(proto_err), 1);
    chk("R7 count stays 0", int'(out_count), 0);
    idle();        chk("R7 err one cycle", int'(proto_err), 0);
    cyc(1, 1, 11); chk("R7 err with start", int'(proto_err), 1);
    chk("R7 start still counted", int'(out_count), 1);
    chk("R8 head after empty push", int'(head_ep), 11);
    cyc(0, 1, 0);  chk("R3 drained", int'(out_count), 0);
  endtask

  task automatic t_full_both();
    for (int i = 0; i < ENTRIES; i++) cyc(1, 0, i + 1);
    chk("R5 full again", int'(rd_accept), 0);
    cyc(1, 1, 15); chk("R6 start ignored when full", int'(out_count), 3);
    chk("R9 reopen with start", int'(rd_accept), 1);
    chk("R8 head after full pop", int'(head_ep), 2);
    for (int i = 0; i < 3; i++) cyc(0, 1, 0);
    chk("R3 final empty", int'(out_count), 0);
    cyc(1, 0, 8);  chk("R6 ep 15 never queued", int'(head_ep), 8);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_fill();
    t_refuse_drain();
    t_both();
    t_err();
    t_full_both();
    idle();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule